// File: doc/BRIEF.md
# Precision Time Real-Time Clock Core

This block keeps time of day for a precision time protocol node. The live time is a seconds counter, a nanoseconds counter, a small phase field, and a 32-bit sub-nanosecond accumulator. While counting is enabled, every clock cycle is one tick. Each tick adds a fixed nanosecond increment to the time and rolls the nanoseconds over into seconds. A signed rate trim can be fed into the accumulator on each tick. When the accumulator carries or borrows, the tick gains or loses one extra nanosecond. This gives software fine control of the clock frequency.

Software never touches the live counters directly. A set of shadow registers stands between the bus and the clock. A read command copies the live time into the shadow registers, so a later register read returns one coherent snapshot. A load command copies the shadow time into the clock. A step command treats the shadow seconds and nanoseconds as two magnitudes. It adds them to the live time or subtracts them from it, as the direction bit selects, and fixes up the carry or borrow between the two fields. A clock-reset command sets the time to zero and keeps the configuration.

All commands are self-clearing bits in the control word. Each command acts in the cycle after the write that sets it.

Top module: `ptp_rtc_core`

## Requirements
- R1: After reset, the control word (0x0500), phase (0x0502), nanoseconds (0x0504), seconds (0x0508) and rate word (0x050C) all read 0.
- R2: Control word bits: bit1 counting enable, bit2 rate-trim enable and bit5 step direction are stored and read back. Bit0 clock reset, bit3 load, bit4 read and bit6 step are command pulses that always read back as 0.
- R3: The live clock advances by 40 ns on every cycle in which counting is enabled and no command acts. It holds still while counting is disabled. N enabled cycles add exactly N×40 ns.
- R4: When nanoseconds reach or pass 1,000,000,000 on a tick, 1,000,000,000 is removed from nanoseconds and seconds increase by one.
- R5: A read command copies live phase, nanoseconds and seconds into the shadow registers one cycle after the write. The shadow registers then keep these values while the live clock runs on.
- R6: A load command copies the shadow phase (bits 2:0, in units of 8 ns), nanoseconds and seconds into the live clock.
- R7: A step with direction 1 adds the shadow seconds and nanoseconds to the live time. A nanosecond sum of 1e9 or more wraps and carries one second.
- R8: A step with direction 0 subtracts the shadow seconds and nanoseconds from the live time. A nanosecond borrow adds 1e9 and takes one more second.
- R9: The rate word holds a 30-bit magnitude in bits 29:0 and a direction in bit31, and reads back with bit30 as 0. With rate trim enabled and direction 1, each tick adds the magnitude to the accumulator, and each carry out adds one extra nanosecond.
- R10: With rate trim enabled and direction 0, each tick subtracts the magnitude from the accumulator, and each borrow removes one nanosecond from that tick.
- R11: With rate trim disabled, the rate word has no effect on the time or the accumulator.
- R12: A clock-reset command clears live seconds, nanoseconds, phase and accumulator. It leaves the stored rate word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
A table of step vectors starts from loaded times that sit next to the second boundary, in both directions. A design that lost the nanosecond carry or borrow would show a seconds value off by one, or nanoseconds above 1e9. A counting run from just below a full second checks both the exact tick count and the rollover. A design with an off-by-one enable window would end 40 ns away from the expected time. Rate runs of 25 ticks with a near-maximum magnitude expect exactly 6 extra nanoseconds when speeding up and 7 fewer when slowing down. A wrong borrow convention, or an accumulator that clock reset does not clear, would miss these counts. The remaining checks cover phase preservation through a load, a snapshot that stays frozen while the clock runs, and a clock reset that leaves the rate word in place.

// File: rtl/ptp_rtc_pkg.sv
package ptp_rtc_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 16;
    localparam int SEC_W        = 32;
    localparam int NS_W         = 32;
    localparam int PHASE_W      = 3;
    localparam int ACC_W        = 32;
    localparam int RATE_W       = 30;
    localparam int RATE_DIR_BIT = 31;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 16'h0500;
    localparam logic [ADDR_W-1:0] ADDR_PHASE = 16'h0502;
    localparam logic [ADDR_W-1:0] ADDR_NS    = 16'h0504;
    localparam logic [ADDR_W-1:0] ADDR_SEC   = 16'h0508;
    localparam logic [ADDR_W-1:0] ADDR_RATE  = 16'h050C;

    // control word bit positions
    localparam int CB_RST  = 0;
    localparam int CB_EN   = 1;
    localparam int CB_TRIM = 2;
    localparam int CB_LOAD = 3;
    localparam int CB_READ = 4;
    localparam int CB_DIR  = 5;
    localparam int CB_STEP = 6;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [NS_W-1:0]    ns;
        logic [SEC_W-1:0]   sec;
        logic [ACC_W-1:0]   acc;
    } live_t;

    typedef struct packed {
        logic               en;
        logic               trim_en;
        logic               step_dir;
        logic               rst_p;
        logic               load_p;
        logic               read_p;
        logic               step_p;
        logic [PHASE_W-1:0] sh_phase;
        logic [NS_W-1:0]    sh_ns;
        logic [SEC_W-1:0]   sh_sec;
        logic [RATE_W-1:0]  rate_mag;
        logic               rate_dir;
    } regs_t;
endpackage

// File: rtl/ptp_rtc_regs.sv
module ptp_rtc_regs
    import ptp_rtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [PHASE_W-1:0]  live_phase,
    input  logic [NS_W-1:0]     live_ns,
    input  logic [SEC_W-1:0]    live_sec,
    output regs_t               regs
);
    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rst_p  = 1'b0;
        r_d.load_p = 1'b0;
        r_d.read_p = 1'b0;
        r_d.step_p = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    r_d.en       = reg_wdata[CB_EN];
                    r_d.trim_en  = reg_wdata[CB_TRIM];
                    r_d.step_dir = reg_wdata[CB_DIR];
                    r_d.rst_p    = reg_wdata[CB_RST];
                    r_d.load_p   = reg_wdata[CB_LOAD];
                    r_d.read_p   = reg_wdata[CB_READ];
                    r_d.step_p   = reg_wdata[CB_STEP];
                end
                ADDR_PHASE: r_d.sh_phase = reg_wdata[PHASE_W-1:0];
                ADDR_NS:    r_d.sh_ns    = reg_wdata[NS_W-1:0];
                ADDR_SEC:   r_d.sh_sec   = reg_wdata[SEC_W-1:0];
                ADDR_RATE: begin
                    r_d.rate_mag = reg_wdata[RATE_W-1:0];
                    r_d.rate_dir = reg_wdata[RATE_DIR_BIT];
                end
                default: ;
            endcase
        end
        // a pending snapshot overrides a same-cycle shadow write
        if (r_q.read_p) begin
            r_d.sh_phase = live_phase;
            r_d.sh_ns    = live_ns;
            r_d.sh_sec   = live_sec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        logic [DATA_W-1:0] ctl_v;
        logic [DATA_W-1:0] rate_v;
        ctl_v          = '0;
        ctl_v[CB_EN]   = r_q.en;
        ctl_v[CB_TRIM] = r_q.trim_en;
        ctl_v[CB_DIR]  = r_q.step_dir;
        rate_v               = DATA_W'(r_q.rate_mag);
        rate_v[RATE_DIR_BIT] = r_q.rate_dir;
        case (reg_addr)
            ADDR_CTRL:  reg_rdata = ctl_v;
            ADDR_PHASE: reg_rdata = DATA_W'(r_q.sh_phase);
            ADDR_NS:    reg_rdata = DATA_W'(r_q.sh_ns);
            ADDR_SEC:   reg_rdata = DATA_W'(r_q.sh_sec);
            ADDR_RATE:  reg_rdata = rate_v;
            default:    reg_rdata = '0;
        endcase
    end

    assign regs = r_q;
endmodule

// File: rtl/ptp_rtc_counter.sv
module ptp_rtc_counter
    import ptp_rtc_pkg::*;
#(
    parameter int TICK_NS    = 40,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  regs_t regs,
    output live_t live
);
    localparam logic [NS_W:0] TICK_X = (NS_W+1)'(TICK_NS);
    localparam logic [NS_W:0] NPS_X  = (NS_W+1)'(NS_PER_SEC);

    live_t l_d, l_q;
    logic [ACC_W:0]   acc_x;
    logic             carry, borrow;
    logic [NS_W:0]    tk_ns, st_ns;
    logic [SEC_W-1:0] tk_sec, st_sec;

    always_comb begin
        // rate trim on the sub-nanosecond accumulator
        carry  = 1'b0;
        borrow = 1'b0;
        acc_x  = {1'b0, l_q.acc};
        if (regs.trim_en) begin
            if (regs.rate_dir) begin
                acc_x = {1'b0, l_q.acc} + (ACC_W+1)'(regs.rate_mag);
                carry = acc_x[ACC_W];
            end else begin
                acc_x  = {1'b0, l_q.acc} - (ACC_W+1)'(regs.rate_mag);
                borrow = acc_x[ACC_W];
            end
        end

        // one tick
        tk_ns  = {1'b0, l_q.ns} + TICK_X + (NS_W+1)'(carry) - (NS_W+1)'(borrow);
        tk_sec = l_q.sec;
        if (tk_ns >= NPS_X) begin
            tk_ns  = tk_ns - NPS_X;
            tk_sec = l_q.sec + SEC_W'(1);
        end

        // step offset, both fields as magnitudes
        if (regs.step_dir) begin
            st_ns  = {1'b0, l_q.ns} + {1'b0, regs.sh_ns};
            st_sec = l_q.sec + regs.sh_sec;
            if (st_ns >= NPS_X) begin
                st_ns  = st_ns - NPS_X;
                st_sec = st_sec + SEC_W'(1);
            end
        end else if (l_q.ns >= regs.sh_ns) begin
            st_ns  = {1'b0, l_q.ns} - {1'b0, regs.sh_ns};
            st_sec = l_q.sec - regs.sh_sec;
        end else begin
            st_ns  = {1'b0, l_q.ns} + NPS_X - {1'b0, regs.sh_ns};
            st_sec = l_q.sec - regs.sh_sec - SEC_W'(1);
        end

        // priority: clock reset, load, step, tick
        l_d = l_q;
        if (regs.rst_p) begin
            l_d = '0;
        end else if (regs.load_p) begin
            l_d.phase = regs.sh_phase;
            l_d.ns    = regs.sh_ns;
            l_d.sec   = regs.sh_sec;
        end else if (regs.step_p) begin
            l_d.ns  = st_ns[NS_W-1:0];
            l_d.sec = st_sec;
        end else if (regs.en) begin
            l_d.acc = acc_x[ACC_W-1:0];
            l_d.ns  = tk_ns[NS_W-1:0];
            l_d.sec = tk_sec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign live = l_q;
endmodule

// File: rtl/ptp_rtc_core.sv
module ptp_rtc_core
    import ptp_rtc_pkg::*;
#(
    parameter int TICK_NS    = 40,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    regs_t regs;
    live_t live;

    // named views for the bound checker
    logic               ctl_en, cmd_rst, cmd_load, cmd_read, cmd_step;
    logic [NS_W-1:0]    live_ns, shadow_ns;
    logic [SEC_W-1:0]   live_sec, shadow_sec;
    logic [PHASE_W-1:0] live_phase;

    ptp_rtc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .live_phase (live.phase),
        .live_ns    (live.ns),
        .live_sec   (live.sec),
        .regs       (regs)
    );

    ptp_rtc_counter #(
        .TICK_NS    (TICK_NS),
        .NS_PER_SEC (NS_PER_SEC)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .regs  (regs),
        .live  (live)
    );

    assign ctl_en     = regs.en;
    assign cmd_rst    = regs.rst_p;
    assign cmd_load   = regs.load_p;
    assign cmd_read   = regs.read_p;
    assign cmd_step   = regs.step_p;
    assign live_ns    = live.ns;
    assign live_sec   = live.sec;
    assign live_phase = live.phase;
    assign shadow_ns  = regs.sh_ns;
    assign shadow_sec = regs.sh_sec;
endmodule

// File: rtl/ptp_rtc_chk.sv
module ptp_rtc_chk
    import ptp_rtc_pkg::*;
#(
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               ctl_en,
    input logic               cmd_rst,
    input logic               cmd_load,
    input logic               cmd_read,
    input logic               cmd_step,
    input logic [NS_W-1:0]    live_ns,
    input logic [SEC_W-1:0]   live_sec,
    input logic [PHASE_W-1:0] live_phase,
    input logic [NS_W-1:0]    shadow_ns,
    input logic [SEC_W-1:0]   shadow_sec
);
    localparam logic [NS_W-1:0] NPS = NS_W'(NS_PER_SEC);

    // R4
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_ns < NPS);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !cmd_rst && !cmd_load && !cmd_step)
        |=> ($stable(live_ns) && $stable(live_sec)));

    // R6
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !cmd_rst)
        |=> (live_ns == $past(shadow_ns) && live_sec == $past(shadow_sec)));

    // R12
    clock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (live_ns == '0 && live_sec == '0 && live_phase == '0));

    // R5
    snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_read |=> (shadow_ns == $past(live_ns) && shadow_sec == $past(live_sec)));

    // R5
    read_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL && reg_wdata[CB_READ]) |=> cmd_read);

    // R2
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL)
        |-> (reg_rdata[CB_RST] == 1'b0 && reg_rdata[CB_LOAD] == 1'b0 &&
             reg_rdata[CB_READ] == 1'b0 && reg_rdata[CB_STEP] == 1'b0));
endmodule

bind ptp_rtc_core ptp_rtc_chk #(.NS_PER_SEC(NS_PER_SEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ctl_en     (ctl_en),
    .cmd_rst    (cmd_rst),
    .cmd_load   (cmd_load),
    .cmd_read   (cmd_read),
    .cmd_step   (cmd_step),
    .live_ns    (live_ns),
    .live_sec   (live_sec),
    .live_phase (live_phase),
    .shadow_ns  (shadow_ns),
    .shadow_sec (shadow_sec)
);

// File: tb/ptp_rtc_core_test.sv
module ptp_rtc_core_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [15:0] A_CTRL  = 16'h0500;
    localparam logic [15:0] A_PHASE = 16'h0502;
    localparam logic [15:0] A_NS    = 16'h0504;
    localparam logic [15:0] A_SEC   = 16'h0508;
    localparam logic [15:0] A_RATE  = 16'h050C;

    localparam logic [31:0] C_RST  = 32'h01;
    localparam logic [31:0] C_EN   = 32'h02;
    localparam logic [31:0] C_TRIM = 32'h04;
    localparam logic [31:0] C_LOAD = 32'h08;
    localparam logic [31:0] C_READ = 32'h10;
    localparam logic [31:0] C_DIR  = 32'h20;
    localparam logic [31:0] C_STEP = 32'h40;

    typedef struct packed {
        logic [31:0] s0;
        logic [31:0] n0;
        logic [31:0] ds;
        logic [31:0] dn;
        logic        up;
        logic [31:0] es;
        logic [31:0] en;
    } vec_t;

    // start time, step magnitudes, direction, expected time (R7 add, R8 subtract)
    localparam vec_t VEC [6] = '{
        '{32'd10, 32'd100,         32'd5,  32'd200, 1'b1, 32'd15, 32'd300},
        '{32'd10, 32'd999_999_900, 32'd1,  32'd200, 1'b1, 32'd12, 32'd100},
        '{32'd0,  32'd999_999_999, 32'd0,  32'd1,   1'b1, 32'd1,  32'd0},
        '{32'd10, 32'd100,         32'd3,  32'd200, 1'b0, 32'd6,  32'd999_999_900},
        '{32'd10, 32'd500,         32'd10, 32'd500, 1'b0, 32'd0,  32'd0},
        '{32'd7,  32'd0,           32'd0,  32'd1,   1'b0, 32'd6,  32'd999_999_999}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    ptp_rtc_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic snap(input logic [31:0] keep, output logic [31:0] s, output logic [31:0] n);
        bus_write(A_CTRL, keep | C_READ);
        @(negedge clk);
        bus_read(A_SEC, s);
        bus_read(A_NS, n);
    endtask

    task automatic set_time(input logic [31:0] s, input logic [31:0] n);
        bus_write(A_SEC, s);
        bus_write(A_NS, n);
        bus_write(A_CTRL, C_LOAD);
    endtask

    // 25 enabled ticks: enable write, 23 idle cycles, then the keep write
    task automatic run25(input logic [31:0] keep);
        bus_write(A_CTRL, keep | C_EN);
        repeat (23) @(negedge clk);
        bus_write(A_CTRL, keep);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] s, n, v, n2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(A_CTRL, v);  check("R1 ctrl", v, 32'h0);
        bus_read(A_PHASE, v); check("R1 phase", v, 32'h0);
        bus_read(A_NS, v);    check("R1 ns", v, 32'h0);
        bus_read(A_SEC, v);   check("R1 sec", v, 32'h0);
        bus_read(A_RATE, v);  check("R1 rate", v, 32'h0);

        // step vector table
        for (int i = 0; i < 6; i++) begin
            set_time(VEC[i].s0, VEC[i].n0);
            bus_write(A_SEC, VEC[i].ds);
            bus_write(A_NS, VEC[i].dn);
            bus_write(A_CTRL, VEC[i].up ? (C_DIR | C_STEP) : C_STEP);
            snap(32'h0, s, n);
            check(VEC[i].up ? "R7 step sec" : "R8 step sec", s, VEC[i].es);
            check(VEC[i].up ? "R7 step ns" : "R8 step ns", n, VEC[i].en);
        end

        // R2 readback of stored bits, commands read as 0
        bus_write(A_CTRL, C_TRIM | C_DIR);
        bus_read(A_CTRL, v); check("R2 stored bits", v, 32'h24);
        bus_write(A_CTRL, C_TRIM | C_DIR | C_READ | C_STEP | C_LOAD);
        bus_read(A_CTRL, v); check("R2 self clear", v, 32'h24);
        bus_write(A_CTRL, 32'h0);

        // R3/R4 counting across the second boundary
        set_time(32'd3, 32'd999_999_500);
        run25(32'h0);
        snap(32'h0, s, n);
        check("R4 rollover sec", s, 32'd4);
        check("R3 25 ticks ns", n, 32'd500);
        repeat (10) @(negedge clk);
        snap(32'h0, s, n);
        check("R3 disabled hold ns", n, 32'd500);

        // R6 phase through load
        bus_write(A_PHASE, 32'd5);
        set_time(32'd1, 32'd8);
        bus_write(A_PHASE, 32'd0);
        snap(32'h0, s, n);
        bus_read(A_PHASE, v); check("R6 phase loaded", v, 32'd5);
        check("R6 ns loaded", n, 32'd8);

        // R5 snapshot frozen while running
        bus_write(A_CTRL, C_EN);
        snap(C_EN, s, n);
        repeat (10) @(negedge clk);
        bus_read(A_NS, n2);
        check("R5 snapshot stable", n2, n);
        bus_write(A_CTRL, 32'h0);

        // R11 rate word ignored with trim off
        bus_write(A_RATE, 32'h3FFF_FFFF | 32'h8000_0000);
        bus_write(A_CTRL, C_RST);
        run25(32'h0);
        snap(32'h0, s, n);
        check("R11 trim off ns", n, 32'd1000);

        // R9 speed up: 25 x (2^30-1) gives 6 carries
        bus_write(A_CTRL, C_RST);
        run25(C_TRIM);
        snap(C_TRIM, s, n);
        check("R9 trim up ns", n, 32'd1006);
        bus_read(A_RATE, v); check("R9 rate readback", v, 32'hBFFF_FFFF);

        // R10 slow down: 7 borrows
        bus_write(A_RATE, 32'h3FFF_FFFF);
        bus_write(A_CTRL, C_RST | C_TRIM);
        run25(C_TRIM);
        snap(C_TRIM, s, n);
        check("R10 trim down ns", n, 32'd993);

        // R12 clock reset keeps the rate word
        bus_write(A_RATE, 32'h8000_0123);
        bus_write(A_PHASE, 32'd3);
        set_time(32'd5, 32'd77);
        bus_write(A_CTRL, C_RST | C_TRIM);
        snap(C_TRIM, s, n);
        check("R12 sec cleared", s, 32'd0);
        check("R12 ns cleared", n, 32'd0);
        bus_read(A_PHASE, v); check("R12 phase cleared", v, 32'd0);
        bus_read(A_RATE, v);  check("R12 rate kept", v, 32'h8000_0123);
        bus_read(A_CTRL, v);  check("R12 ctrl kept", v, 32'h04);

        report();
    end
endmodule